// File: doc/BRIEF.md
# Hot-Insertion Enable Gate

This block sits between a bridge's stored command-register enables and the logic that uses them. When software has armed hot-insertion mode and the shared general-purpose pin 3 is set up as an input, a high level on that pin hides the I/O-space, memory-space and bus-master enables from the target and master logic. Software still reads back the values it wrote. When the pin falls again, the stored values take effect once more and software does not have to write them again.

Each incoming transaction is presented as an encoded request kind. The block returns a single accept decision for it. While the gate is closed, new I/O and memory target accesses are refused on both sides of the bridge, and delayed completions are held back. Type 0 configuration accesses still get through. Posted writes and delayed requests that were already queued can still drain, so the bridge can reach a quiet state. The pin is brought into the clock domain through a synchronizer. A halted output tells software when the gate is closed and no queued work remains, which is the point at which it may reset the secondary bus.

Top module: `hotplug_enable_gate`

## Requirements
- R1: The gate is closed (`gate_active`=1) only when `live_mode_en`=1, `gpio3_oe`=0 (pin configured as input only) and the synchronized pin level is 1. In every other case `gate_active`=0.
- R2: While the gate is closed, `eff_io_en`, `eff_mem_en` and `eff_master_en` are all 0.
- R3: `rd_io_en`, `rd_mem_en` and `rd_master_en` always equal the stored enables `cmd_io_en`, `cmd_mem_en` and `cmd_master_en`, whether or not the gate is closed.
- R4: While the gate is open, each effective enable equals its stored enable. After the pin falls, the stored values return without any rewrite.
- R5: Request kind 0 (I/O) is accepted only when `eff_io_en`=1, and kind 1 (memory) only when `eff_mem_en`=1. Both are therefore refused while the gate is closed.
- R6: Request kind 2 (Type 0 configuration) is always accepted when valid, including while the gate is closed.
- R7: Request kind 3 (queued posted write) and kind 4 (queued delayed request) are accepted when the stored `cmd_master_en`=1, even while the gate is closed.
- R8: Request kind 5 (delayed completion return) is accepted only while the gate is open.
- R9: `gpio3_pin` passes through two flops. A level present at a rising edge first affects `gate_active` after the second rising edge from that one.
- R10: `halted`=1 exactly when the gate is closed and `queued_cnt`=0.
- R11: While `rst_n`=0 the synchronizer holds 0, so `gate_active`=0 and `halted`=0 during reset and right after it.
- R12: `req_accept` is 0 when `req_valid`=0, and for the unused request kinds 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_io_en | input | 1 | Stored I/O-space enable |
| cmd_mem_en | input | 1 | Stored memory-space enable |
| cmd_master_en | input | 1 | Stored bus-master enable |
| live_mode_en | input | 1 | Hot-insertion mode arm bit |
| gpio3_oe | input | 1 | Pin 3 output-enable setting (0 = input only) |
| gpio3_pin | input | 1 | Asynchronous pin 3 level |
| queued_cnt | input | QCNT_W | Count of queued master work still to finish |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Encoded request kind |
| eff_io_en | output | 1 | Effective I/O enable |
| eff_mem_en | output | 1 | Effective memory enable |
| eff_master_en | output | 1 | Effective master enable |
| rd_io_en | output | 1 | Readback of I/O enable |
| rd_mem_en | output | 1 | Readback of memory enable |
| rd_master_en | output | 1 | Readback of master enable |
| gate_active | output | 1 | Masking in force |
| req_accept | output | 1 | Accept decision for the current request |
| halted | output | 1 | Gate closed and no queued work left |

## Verification
The assertions check several rules on every clock: forced-zero enables whenever the gate is closed, pass-through of the stored enables while it is open, readback equal to the stored values, unconditional acceptance of configuration requests, held-back completions, the exact meaning of halted, and the two-edge pin latency. Some behaviour can only be shown by the bench's scenarios: the stored enables coming back when the pin drops without any rewrite, the draining of queued work following the unmasked master enable, and the reset state. The same holds for every mode and pin combination under random stimulus.

// File: rtl/hig_pkg.sv
package hig_pkg;

   localparam int REQ_KIND_W = 3;

   typedef enum logic [REQ_KIND_W-1:0] {
      RK_IO      = 3'd0,
      RK_MEM     = 3'd1,
      RK_CFG0    = 3'd2,
      RK_PWRITE  = 3'd3,
      RK_DREQ    = 3'd4,
      RK_DCPL    = 3'd5,
      RK_RSVD6   = 3'd6,
      RK_RSVD7   = 3'd7
   } req_kind_e;

   typedef struct packed {
      logic io;
      logic mem;
      logic mst;
   } cmd_en_t;

endpackage

// File: rtl/hig_sync.sv
module hig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   localparam int LAST = STAGES - 1;

   initial begin
      if (STAGES < 2) $error("hig_sync: STAGES must be at least 2");
   end

   logic [LAST:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= 1'b0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain[LAST];
endmodule

// File: rtl/hig_mask.sv
module hig_mask
   import hig_pkg::*;
(
   input  logic    mode_arm,
   input  logic    pin_oe,
   input  logic    pin_sync,
   input  cmd_en_t stored,
   output logic    gate,
   output cmd_en_t effective
);
   logic armed;

   always_comb begin
      armed = mode_arm & ~pin_oe;
      gate  = armed & pin_sync;
      if (gate) begin
         effective = '0;
      end else begin
         effective = stored;
      end
   end
endmodule

// File: rtl/hig_decide.sv
module hig_decide
   import hig_pkg::*;
#(
   parameter int QCNT_W = 8
) (
   input  logic                  valid,
   input  logic [REQ_KIND_W-1:0] kind,
   input  logic                  gate,
   input  cmd_en_t               stored,
   input  cmd_en_t               effective,
   input  logic [QCNT_W-1:0]     qcnt,
   output logic                  accept,
   output logic                  halted
);
   initial begin
      if (QCNT_W < 1) $error("hig_decide: QCNT_W must be positive");
   end

   req_kind_e kd;
   logic      raw;

   always_comb begin
      kd = req_kind_e'(kind);
      unique case (kd)
         RK_IO:     raw = effective.io;
         RK_MEM:    raw = effective.mem;
         RK_CFG0:   raw = 1'b1;
         RK_PWRITE: raw = stored.mst;
         RK_DREQ:   raw = stored.mst;
         RK_DCPL:   raw = ~gate;
         default:   raw = 1'b0;
      endcase
      accept = valid & raw;
      halted = gate & (qcnt == '0);
   end
endmodule

// File: rtl/hotplug_enable_gate.sv
module hotplug_enable_gate
   import hig_pkg::*;
#(
   parameter int QCNT_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_io_en,
   input  logic              cmd_mem_en,
   input  logic              cmd_master_en,
   input  logic              live_mode_en,
   input  logic              gpio3_oe,
   input  logic              gpio3_pin,
   input  logic [QCNT_W-1:0] queued_cnt,
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   output logic              eff_io_en,
   output logic              eff_mem_en,
   output logic              eff_master_en,
   output logic              rd_io_en,
   output logic              rd_mem_en,
   output logic              rd_master_en,
   output logic              gate_active,
   output logic              req_accept,
   output logic              halted
);
   initial begin
      if (SYNC_STAGES < 2) $error("hotplug_enable_gate: SYNC_STAGES < 2");
      if (QCNT_W < 1)      $error("hotplug_enable_gate: QCNT_W < 1");
   end

   logic    pin_s;
   cmd_en_t stored_en;
   cmd_en_t eff_en;

   assign stored_en = '{io: cmd_io_en, mem: cmd_mem_en, mst: cmd_master_en};

   hig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (gpio3_pin),
      .sync_out (pin_s)
   );

   hig_mask u_mask (
      .mode_arm  (live_mode_en),
      .pin_oe    (gpio3_oe),
      .pin_sync  (pin_s),
      .stored    (stored_en),
      .gate      (gate_active),
      .effective (eff_en)
   );

   hig_decide #(.QCNT_W(QCNT_W)) u_decide (
      .valid     (req_valid),
      .kind      (req_kind),
      .gate      (gate_active),
      .stored    (stored_en),
      .effective (eff_en),
      .qcnt      (queued_cnt),
      .accept    (req_accept),
      .halted    (halted)
   );

   assign eff_io_en     = eff_en.io;
   assign eff_mem_en    = eff_en.mem;
   assign eff_master_en = eff_en.mst;
   assign rd_io_en      = stored_en.io;
   assign rd_mem_en     = stored_en.mem;
   assign rd_master_en  = stored_en.mst;
endmodule

// File: rtl/hig_checker.sv
module hig_checker #(
   parameter int QCNT_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_io_en,
   input logic              cmd_mem_en,
   input logic              cmd_master_en,
   input logic              live_mode_en,
   input logic              gpio3_oe,
   input logic              gpio3_pin,
   input logic [QCNT_W-1:0] queued_cnt,
   input logic              req_valid,
   input logic [2:0]        req_kind,
   input logic              eff_io_en,
   input logic              eff_mem_en,
   input logic              eff_master_en,
   input logic              rd_io_en,
   input logic              rd_mem_en,
   input logic              rd_master_en,
   input logic              gate_active,
   input logic              req_accept,
   input logic              halted
);
   a_r1_gate_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      gate_active |-> (live_mode_en && !gpio3_oe));

   a_r2_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
      gate_active |-> (!eff_io_en && !eff_mem_en && !eff_master_en));

   a_r3_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_io_en == cmd_io_en) && (rd_mem_en == cmd_mem_en) && (rd_master_en == cmd_master_en));

   a_r4_open_passes: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_active |-> (eff_io_en == cmd_io_en && eff_mem_en == cmd_mem_en
                        && eff_master_en == cmd_master_en));

   a_r6_cfg0_ok: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 3'd2) |-> req_accept);

   a_r8_cpl_held: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_active && req_kind == 3'd5) |-> !req_accept);

   a_r10_halted: assert property (@(posedge clk) disable iff (!rst_n)
      halted == (gate_active && queued_cnt == '0));

   a_r12_idle_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid || req_kind[2:1] == 2'b11) |-> !req_accept);

   generate
      if (SYNC_STAGES == 2) begin : g_lat
         a_r9_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(rst_n, 2))
            |-> (gate_active == (live_mode_en && !gpio3_oe && $past(gpio3_pin, 2))));
      end
   endgenerate
endmodule

bind hotplug_enable_gate hig_checker #(.QCNT_W(QCNT_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en),
   .cmd_master_en(cmd_master_en), .live_mode_en(live_mode_en), .gpio3_oe(gpio3_oe),
   .gpio3_pin(gpio3_pin), .queued_cnt(queued_cnt), .req_valid(req_valid),
   .req_kind(req_kind), .eff_io_en(eff_io_en), .eff_mem_en(eff_mem_en),
   .eff_master_en(eff_master_en), .rd_io_en(rd_io_en), .rd_mem_en(rd_mem_en),
   .rd_master_en(rd_master_en), .gate_active(gate_active), .req_accept(req_accept),
   .halted(halted)
);

// File: tb/hotplug_enable_gate_test.sv
module hotplug_enable_gate_test;
   localparam int QW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_io_en = 0, cmd_mem_en = 0, cmd_master_en = 0;
   logic          live_mode_en = 0, gpio3_oe = 1, gpio3_pin = 0;
   logic [QW-1:0] queued_cnt = '0;
   logic          req_valid = 0;
   logic [2:0]    req_kind = '0;
   logic eff_io_en, eff_mem_en, eff_master_en;
   logic rd_io_en, rd_mem_en, rd_master_en;
   logic gate_active, req_accept, halted;

   int n_cmp = 0;
   int n_bad = 0;
   bit p1 = 0, p2 = 0;   // bench model of the two-edge pin path (R9)

   always #4 clk = ~clk;

   hotplug_enable_gate #(.QCNT_W(QW), .SYNC_STAGES(2)) uut (.*);

   task automatic check(input string tag, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit exp_gate();
      return live_mode_en && !gpio3_oe && p2;
   endfunction

   function automatic bit exp_accept(bit g);
      if (!req_valid) return 0;
      case (req_kind)
         3'd0: return cmd_io_en && !g;
         3'd1: return cmd_mem_en && !g;
         3'd2: return 1;
         3'd3, 3'd4: return cmd_master_en;
         3'd5: return !g;
         default: return 0;
      endcase
   endfunction

   function automatic string acc_tag();
      case (req_kind)
         3'd0, 3'd1: return "R5";
         3'd2: return "R6";
         3'd3, 3'd4: return "R7";
         3'd5: return "R8";
         default: return "R12";
      endcase
   endfunction

   task automatic tick();
      @(posedge clk);
      p2 = p1;
      p1 = gpio3_pin;
      #2;
   endtask

   task automatic check_all();
      bit g;
      g = exp_gate();
      check("R1", gate_active, g);
      check(g ? "R2" : "R4", eff_io_en, cmd_io_en && !g);
      check(g ? "R2" : "R4", eff_mem_en, cmd_mem_en && !g);
      check(g ? "R2" : "R4", eff_master_en, cmd_master_en && !g);
      check("R3", {rd_io_en, rd_mem_en, rd_master_en} == {cmd_io_en, cmd_mem_en, cmd_master_en}, 1'b1);
      check(acc_tag(), req_accept, exp_accept(g));
      check("R10", halted, g && queued_cnt == 0);
   endtask

   initial begin
      #(200000 * 8);
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      gpio3_pin = 1; live_mode_en = 1; gpio3_oe = 0;
      repeat (3) @(posedge clk);
      #2;
      check("R11", gate_active, 1'b0);
      check("R11", halted, 1'b0);
      @(negedge clk); rst_n = 1; gpio3_pin = 0;
      p1 = 0; p2 = 0;
      cmd_io_en = 1; cmd_mem_en = 1; cmd_master_en = 1;
      tick();
      check("R11", gate_active, 1'b0);

      // R9 latency: raise pin, gate follows after second edge
      @(negedge clk); gpio3_pin = 1;
      tick(); check("R9", gate_active, 1'b0);
      tick(); check("R9", gate_active, 1'b1);
      check("R2", eff_io_en, 1'b0);
      check("R3", rd_io_en, 1'b1);
      // masked: cfg0 accepted, drain accepted, completion refused
      @(negedge clk); req_valid = 1; req_kind = 3'd2; #1; check("R6", req_accept, 1'b1);
      req_kind = 3'd3; #1; check("R7", req_accept, 1'b1);
      req_kind = 3'd4; #1; check("R7", req_accept, 1'b1);
      req_kind = 3'd5; #1; check("R8", req_accept, 1'b0);
      req_kind = 3'd1; #1; check("R5", req_accept, 1'b0);
      queued_cnt = 3; #1; check("R10", halted, 1'b0);
      queued_cnt = 0; #1; check("R10", halted, 1'b1);
      // R4 release without rewrite
      gpio3_pin = 0;
      tick(); tick();
      check("R4", eff_mem_en, 1'b1);
      check("R4", eff_master_en, 1'b1);
      // R1: output-enabled pin keeps gate open
      @(negedge clk); gpio3_oe = 1; gpio3_pin = 1;
      tick(); tick(); check("R1", gate_active, 1'b0);
      // R12 reserved kind and idle
      req_kind = 3'd6; #1; check("R12", req_accept, 1'b0);
      req_valid = 0; req_kind = 3'd2; #1; check("R12", req_accept, 1'b0);

      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if ($urandom_range(0, 7) == 0) gpio3_pin = ~gpio3_pin;
         if ($urandom_range(0, 15) == 0) live_mode_en = ~live_mode_en;
         if ($urandom_range(0, 15) == 0) gpio3_oe = ~gpio3_oe;
         {cmd_io_en, cmd_mem_en, cmd_master_en} = 3'($urandom);
         queued_cnt = QW'($urandom_range(0, 3));
         req_valid = ($urandom_range(0, 3) != 0);
         req_kind = 3'($urandom);
         tick();
         check_all();
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule